// File: doc/BRIEF.md
# Acceleration Sample Buffer with Output Holding Stage

This block queues three-axis acceleration samples between a sensor datapath and a byte-wide register read port. Each time the producer raises its valid strobe, an X, Y and Z word of 16 bits each is taken in together as one sample. Samples wait in a storage array of DEPTH entries. In front of the read port sits one holding register, the output stage, so the block can hold DEPTH+1 samples at once. With the default depth of 32 that is 33 samples.

The host reads through an access made of one or more byte reads. It marks the closing byte of each access with a last flag. If any byte of the access fell on a data address, the sample in the output stage is retired when the access closes. This happens whether the host read one byte or all six, so software has to fetch a whole sample in a single burst. A status byte reports how many samples are available, a sticky trigger flag, and a sticky overflow flag. When the output stage has emptied, it refills from the head of the array on the following cycle. When the array is empty, a new sample goes straight into the output stage.

Top module: `accel_sample_fifo`

## Requirements
- R1: A synchronous active-high reset empties the buffer and clears both flags, so a status read afterwards returns 0x00.
- R2: Address 6 returns the status byte. Bit 7 is the trigger flag, bit 6 is the overflow flag, and bits 5:0 hold the number of available samples, which is the output stage plus the array entries.
- R3: Up to DEPTH+1 samples (33 by default) are accepted, and the count field reaches that value.
- R4: A valid strobe that arrives while DEPTH+1 samples are held is dropped. It sets the overflow flag, which stays set until reset. The count and the stored samples are unchanged.
- R5: Addresses 0 to 5 return the output-stage sample as X low, X high, Y low, Y high, Z low, Z high. Each byte appears on rd_data one cycle after the rd_en cycle. Address 7 reads as 0x00.
- R6: An access that touched any data address retires the output-stage sample on its closing rd_last cycle, and the count drops by one. This holds for a single byte, a partial burst or a full six-byte burst. An access that touched only addresses 6 or 7 retires nothing.
- R7: Samples leave in the order they arrived, including across a full buffer.
- R8: A sample that arrives when both the array and the output stage are empty is readable from the next cycle. After a retire, the next sample is loaded into the output stage from the array head one cycle later.
- R9: A data access while the buffer is empty returns the most recently retired sample and leaves the count at 0.
- R10: A pulse on trig_evt sets the trigger flag, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Producer strobe: the sample words are valid this cycle |
| smp_x | input | 16 | X acceleration word |
| smp_y | input | 16 | Y acceleration word |
| smp_z | input | 16 | Z acceleration word |
| trig_evt | input | 1 | Trigger event pulse |
| rd_en | input | 1 | Byte read request |
| rd_addr | input | 3 | Byte address: 0 to 5 data, 6 status, 7 reserved |
| rd_last | input | 1 | Marks the closing byte of an access |
| rd_data | output | 8 | Registered read byte |

## Verification
The bench fills the buffer to exactly 33 samples and then offers one more. A design that counted capacity as the array depth alone would stop at 32. A design with a faulty drop path would overwrite a queued sample or fail to raise the overflow flag, and the full drain in arrival order would expose either fault. Single-byte and two-byte accesses check that a partial read still retires a whole sample. A design that popped per byte, or only after six bytes, would show the wrong count or hand back the wrong next sample. Status-only accesses and reads of an empty buffer must leave the count alone and return the last sample, so a design that retired or underflowed on these would be caught.

// File: rtl/accel_fifo_pkg.sv
package accel_fifo_pkg;
  parameter int AXIS_W = 16;
  localparam int SMP_W = 3 * AXIS_W;
  localparam int DATA_BYTES = SMP_W / 8;
  localparam int ADDR_W = 3;
  localparam int STAT_CNT_W = 6;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd6;

  typedef struct packed {
    logic [AXIS_W-1:0] z;
    logic [AXIS_W-1:0] y;
    logic [AXIS_W-1:0] x;
  } smp_t;
endpackage

// File: rtl/accel_fifo_store.sv
module accel_fifo_store
  import accel_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  smp_t             din,
  input  logic             retire,
  output smp_t             out_smp,
  output logic             out_vld,
  output logic [CNT_W-1:0] total,
  output logic             drop
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [SMP_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] arr_cnt;
  logic accept, pop, reload, direct, wr_arr;

  assign total  = arr_cnt + CNT_W'(out_vld);
  assign accept = push && (total != CAP);
  assign drop   = push && (total == CAP);
  assign pop    = retire && out_vld;
  assign reload = !out_vld && (arr_cnt != '0);
  assign direct = accept && !out_vld && (arr_cnt == '0);
  assign wr_arr = accept && !direct;

  always_ff @(posedge clk) begin
    if (wr_arr) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_smp <= '0;
    end else if (reload) begin
      out_smp <= mem[rd_ptr];
    end else if (direct) begin
      out_smp <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      arr_cnt <= '0;
    end else begin
      if (reload || direct) out_vld <= 1'b1;
      else if (pop) out_vld <= 1'b0;
      if (wr_arr) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (reload) rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      arr_cnt <= arr_cnt + CNT_W'(wr_arr) - CNT_W'(reload);
    end
  end

  p_full_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (drop && !pop) |=> (total == CAP));
  p_reload_r8: assert property (@(posedge clk) disable iff (rst)
    (!out_vld && arr_cnt != '0) |=> out_vld);
  p_direct_r8: assert property (@(posedge clk) disable iff (rst)
    (push && !out_vld && arr_cnt == '0) |=> (out_vld && out_smp == $past(din)));
  p_pop_r6: assert property (@(posedge clk) disable iff (rst)
    (pop && !push) |=> (total == $past(total) - 1'b1));
  p_empty_read_r9: assert property (@(posedge clk) disable iff (rst)
    (retire && total == '0 && !push) |=> (total == '0 && $stable(out_smp)));
endmodule

// File: rtl/accel_fifo_flags.sv
module accel_fifo_flags (
  input  logic clk,
  input  logic rst,
  input  logic trig_evt,
  input  logic drop,
  output logic trig_q,
  output logic ovf_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (trig_evt) trig_q <= 1'b1;
      if (drop) ovf_q <= 1'b1;
    end
  end

  p_trig_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    trig_q |=> trig_q);
  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> ovf_q);
  p_ovf_set_r4: assert property (@(posedge clk) disable iff (rst)
    drop |=> ovf_q);
endmodule

// File: rtl/accel_fifo_regport.sv
module accel_fifo_regport
  import accel_fifo_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_last,
  input  smp_t              out_smp,
  input  logic [CNT_W-1:0]  total,
  input  logic              trig_q,
  input  logic              ovf_q,
  output logic [7:0]        rd_data,
  output logic              retire
);
  logic touched;
  logic data_hit;
  logic [SMP_W-1:0] flat;
  logic [7:0] byte_sel;

  assign flat     = out_smp;
  assign data_hit = rd_en && (rd_addr < ADDR_W'(DATA_BYTES));
  assign retire   = rd_en && rd_last && (touched || data_hit);

  always_comb begin
    byte_sel = 8'h00;
    for (int k = 0; k < DATA_BYTES; k++) begin
      if (rd_addr == ADDR_W'(k)) byte_sel = flat[k*8 +: 8];
    end
    if (rd_addr == ADDR_STATUS)
      byte_sel = {trig_q, ovf_q, STAT_CNT_W'(total)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      touched <= 1'b0;
      rd_data <= 8'h00;
    end else begin
      if (rd_en && rd_last) touched <= 1'b0;
      else if (data_hit) touched <= 1'b1;
      if (rd_en) rd_data <= byte_sel;
    end
  end

  p_status_only_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_last && !touched && rd_addr >= ADDR_STATUS) |-> !retire);
  p_rd_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/accel_sample_fifo.sv
module accel_sample_fifo
  import accel_fifo_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [AXIS_W-1:0] smp_x,
  input  logic [AXIS_W-1:0] smp_y,
  input  logic [AXIS_W-1:0] smp_z,
  input  logic              trig_evt,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_last,
  output logic [7:0]        rd_data
);
  localparam int CNT_W = $clog2(DEPTH + 2);

  smp_t din, out_smp;
  logic out_vld, drop, retire, trig_q, ovf_q;
  logic [CNT_W-1:0] total;

  assign din = '{z: smp_z, y: smp_y, x: smp_x};

  accel_fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .push(smp_valid), .din(din), .retire(retire),
    .out_smp(out_smp), .out_vld(out_vld), .total(total), .drop(drop)
  );

  accel_fifo_flags u_flags (
    .clk(clk), .rst(rst), .trig_evt(trig_evt), .drop(drop),
    .trig_q(trig_q), .ovf_q(ovf_q)
  );

  accel_fifo_regport #(.CNT_W(CNT_W)) u_port (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_last(rd_last), .out_smp(out_smp), .total(total),
    .trig_q(trig_q), .ovf_q(ovf_q), .rd_data(rd_data), .retire(retire)
  );

  p_cap_r3: assert property (@(posedge clk) disable iff (rst)
    total <= CNT_W'(DEPTH + 1));
endmodule

// File: tb/accel_sample_fifo_test.sv
module accel_sample_fifo_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic [15:0] smp_x = '0, smp_y = '0, smp_z = '0;
  logic trig_evt = 1'b0;
  logic rd_en = 1'b0;
  logic [2:0] rd_addr = '0;
  logic rd_last = 1'b0;
  logic [7:0] rd_data;

  int total_n = 0;
  int bad_n = 0;
  logic [47:0] exp_q[$];
  logic trig_m = 1'b0;
  logic ovf_m = 1'b0;
  logic [47:0] last_m = '0;

  always #2 clk = ~clk;

  accel_sample_fifo uut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_x(smp_x),
    .smp_y(smp_y), .smp_z(smp_z), .trig_evt(trig_evt), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_last(rd_last), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [47:0] got,
                     input logic [47:0] exp);
    total_n++;
    if (!ok) begin
      bad_n++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic push(input logic [15:0] x, input logic [15:0] y,
                      input logic [15:0] z);
    smp_valid = 1'b1; smp_x = x; smp_y = y; smp_z = z;
    @(negedge clk);
    smp_valid = 1'b0;
    if (exp_q.size() < 33) exp_q.push_back({z, y, x});
    else ovf_m = 1'b1;
  endtask

  task automatic rd_byte(input logic [2:0] a, input logic l, output logic [7:0] d);
    rd_en = 1'b1; rd_addr = a; rd_last = l;
    @(negedge clk);
    d = rd_data;
    rd_en = 1'b0; rd_last = 1'b0;
  endtask

  task automatic chk_status(input string req);
    logic [7:0] d;
    logic [7:0] e;
    rd_byte(3'd6, 1'b1, d);
    e = {trig_m, ovf_m, 6'(exp_q.size())};
    chk(d == e, req, 48'(d), 48'(e));
  endtask

  // Monitor side: one full burst, compared against the scoreboard head.
  task automatic read_sample(input string req);
    logic [47:0] got;
    logic [47:0] exp;
    logic [7:0] d;
    for (int k = 0; k < 6; k++) begin
      rd_byte(3'(k), k == 5, d);
      got[k*8 +: 8] = d;
    end
    @(negedge clk);
    if (exp_q.size() != 0) begin
      exp = exp_q.pop_front();
      last_m = exp;
    end else begin
      exp = last_m;
    end
    chk(got == exp, req, got, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad_n++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [47:0] e;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_status("R1 reset status");

    push(16'h1A2B, 16'h3C4D, 16'h5E6F);
    push(16'h0102, 16'h0304, 16'h0506);
    push(16'hA0B0, 16'hC0D0, 16'hE0F0);
    chk_status("R2 count after three");
    read_sample("R5 R8 direct-loaded sample bytes");
    chk_status("R6 count after full burst");

    // single-byte access on Y low retires the whole sample
    rd_byte(3'd2, 1'b1, d);
    @(negedge clk);
    e = exp_q.pop_front();
    last_m = e;
    chk(d == e[23:16], "R6 single byte value", 48'(d), 48'(e[23:16]));
    chk_status("R6 count after single byte");
    chk_status("R6 status access does not retire");
    rd_byte(3'd7, 1'b1, d);
    chk(d == 8'h00, "R5 reserved address", 48'(d), 48'h0);
    chk_status("R6 reserved access does not retire");
    read_sample("R7 third sample");
    chk_status("R6 empty after drain");
    read_sample("R9 empty read repeats last sample");
    chk_status("R9 count stays zero");

    for (int i = 0; i < 33; i++)
      push(16'(i * 3 + 1), 16'(16'h4000 + i), 16'(16'h8000 ^ (i << 4)));
    chk_status("R3 count reaches 33");
    push(16'hDEAD, 16'hBEEF, 16'hCAFE);
    chk_status("R4 drop sets overflow, count held");
    trig_evt = 1'b1;
    @(negedge clk);
    trig_evt = 1'b0;
    trig_m = 1'b1;
    chk_status("R10 trigger flag set");
    for (int i = 0; i < 33; i++) read_sample("R7 R4 drain in order");
    chk_status("R4 R10 flags sticky after drain");

    push(16'h1111, 16'h2222, 16'h3333);
    push(16'h4444, 16'h5555, 16'h6666);
    rd_byte(3'd4, 1'b0, d);
    rd_byte(3'd5, 1'b1, d);
    @(negedge clk);
    e = exp_q.pop_front();
    chk(d == e[47:40], "R6 partial burst value", 48'(d), 48'(e[47:40]));
    read_sample("R6 R8 next sample after partial burst");

    push(16'h7777, 16'h8888, 16'h9999);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    exp_q.delete();
    trig_m = 1'b0;
    ovf_m = 1'b0;
    chk_status("R1 reset clears count and flags");

    $display("  test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end
endmodule